// File: doc/BRIEF.md
# Packed-Decimal Adder/Subtractor

This unit adds or subtracts two packed binary-coded-decimal operands of two decimal digits each (one byte) and stores a decimally corrected result. One binary adder and one correction path serve both operations. For subtraction, each digit of the second operand is first replaced by its nines' complement. The carry input then supplies the "+1" that turns this into a ten's complement. Because the carry input is a plain bit, it doubles as a chaining input. Wider decimal numbers are processed one byte at a time, and the decimal carry of one byte is fed into the next.

The raw binary sum is corrected one digit at a time, starting from the least significant digit. A digit receives +6 when the binary sum carried out of that digit, or when the digit value (plus any correction carry from the digit below) is larger than nine. The outputs are the corrected byte, the carry out of bit 3 of the raw binary sum, and a decimal carry out of the top digit. All three are captured in registers on a cycle in which the operation strobe is high, and they hold their values otherwise. Checking for illegal digits and sequencing multi-byte operations are left to the surrounding logic.

Top module: `bcd_addsub_unit`

## Requirements
- R1: While reset is active and after it is released, the result, the half-carry flag and the decimal-carry flag are all 0 until the first strobed operation.
- R2: In a cycle with `op_valid` low, the three outputs keep their previous values, whatever the other inputs do.
- R3: Addition (`op_sub`=0) with legal digits yields the BCD encoding of (A + B + carry_in) mod 100, with the tens digit in bits 7:4. `dec_carry` is 1 exactly when A + B + carry_in is 100 or more.
- R4: `half_carry` equals the carry from bit 3 into bit 4 of the raw binary sum A + B' + carry_in. Here B' is B for addition and the digit-wise nines' complement (9 − digit) for subtraction.
- R5: 0x39 + 0x28 with carry_in 0 gives 0x67, `half_carry` 1 and `dec_carry` 0, because the low digit is corrected on the half-carry alone.
- R6: 0x56 + 0x29 with carry_in 0 gives 0x85, `half_carry` 0 and `dec_carry` 0, because the low digit is corrected for exceeding nine.
- R7: Subtraction (`op_sub`=1) yields the BCD encoding of (A + (99 − B) + carry_in) mod 100. With carry_in 1 this is A − B mod 100, and `dec_carry` is 1 (no borrow) exactly when A ≥ B.
- R8: 0x42 − 0x24 with carry_in 1 gives 0x18 with `dec_carry` 1. A subtrahend equal to the minuend gives 0x00 with `dec_carry` 1.
- R9: carry_in adds one unit to the low digit. 0x99 + 0x00 with carry_in 1 gives 0x00 with `dec_carry` 1. A subtraction with carry_in 0 acts as a borrow-in.
- R10: The largest case, 0x99 + 0x99 with carry_in 1, gives 0x99 with `dec_carry` 1 and `half_carry` 1. A carry produced by a correction ripples into the next digit, so 0x99 + 0x01 gives 0x00 with `dec_carry` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Strobe: capture the result of the current operands |
| op_sub | input | 1 | 0 = add, 1 = subtract through ten's complement |
| carry_in | input | 1 | Decimal carry in (no-borrow in for subtraction) |
| opnd_a | input | 8 | First operand, packed BCD |
| opnd_b | input | 8 | Second operand (addend or subtrahend), packed BCD |
| sum_bcd | output | 8 | Registered corrected result, packed BCD |
| half_carry | output | 1 | Registered carry from bit 3 into bit 4 of the raw binary sum |
| dec_carry | output | 1 | Registered decimal carry out (no-borrow on subtraction) |

## Verification
The assertions check, on every cycle, several properties that hold for any operands. The outputs stay frozen while the strobe is low. A result computed from legal digits contains only legal digits. Adding zero with no carry returns the first operand unchanged. Subtracting a value from itself with carry-in set returns zero with a carry. The half-carry agrees with a nibble-sum computed independently. The exact corrected values need the bench's scenarios. These include the specific low-digit and high-digit correction cases, a correction carry that ripples up through both digits, borrow behaviour on subtraction, and an exhaustive sweep over all legal operand pairs in both modes, compared against a decimal model.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
    localparam digit_t DIGIT_MAX = 4'd9;
    localparam digit_t DIGIT_ADJ = 4'd6;
endpackage

// File: rtl/bcd_nines_comp.sv
// Digit-wise nines' complement of a packed-decimal word, or pass-through.
module bcd_nines_comp #(
    parameter int DIGITS = 2
) (
    input  logic                                en_i,
    input  logic [DIGITS*bcd_pkg::DIGIT_W-1:0]  val_i,
    output logic [DIGITS*bcd_pkg::DIGIT_W-1:0]  val_o
);
    localparam int DW = bcd_pkg::DIGIT_W;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign val_o[g*DW +: DW] = en_i ? (bcd_pkg::DIGIT_MAX - val_i[g*DW +: DW])
                                        : val_i[g*DW +: DW];
    end
endmodule

// File: rtl/bcd_digit_fix.sv
// Decimal correction of one raw nibble of a binary sum.
module bcd_digit_fix
    import bcd_pkg::*;
(
    input  digit_t raw_i,        // nibble of the raw binary sum
    input  logic   bin_carry_i,  // binary carry out of this nibble in the raw sum
    input  logic   adj_carry_i,  // carry produced by correcting the digit below
    output digit_t dig_o,
    output logic   adj_carry_o
);
    logic [DIGIT_W:0] t_val;
    logic [DIGIT_W:0] u_val;
    logic             need_fix;

    always_comb begin
        t_val       = {1'b0, raw_i} + {{DIGIT_W{1'b0}}, adj_carry_i};
        need_fix    = bin_carry_i || (t_val > {1'b0, DIGIT_MAX});
        u_val       = t_val + (need_fix ? {1'b0, DIGIT_ADJ} : '0);
        dig_o       = u_val[DIGIT_W-1:0];
        adj_carry_o = u_val[DIGIT_W];
    end
endmodule

// File: rtl/bcd_addsub_unit.sv
// Packed-decimal add/subtract with a single add-then-correct path.
module bcd_addsub_unit #(
    parameter int DIGITS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               op_valid,
    input  logic                               op_sub,
    input  logic                               carry_in,
    input  logic [DIGITS*bcd_pkg::DIGIT_W-1:0] opnd_a,
    input  logic [DIGITS*bcd_pkg::DIGIT_W-1:0] opnd_b,
    output logic [DIGITS*bcd_pkg::DIGIT_W-1:0] sum_bcd,
    output logic                               half_carry,
    output logic                               dec_carry
);
    localparam int DW = bcd_pkg::DIGIT_W;
    localparam int W  = DIGITS * DW;

    logic [W-1:0]      b_eff;
    logic [W:0]        raw_sum;
    logic [DIGITS-1:0] bin_cy;
    logic [DIGITS:0]   adj_cy;
    logic [W-1:0]      fixed_sum;
    logic              carry_nxt;

    bcd_nines_comp #(.DIGITS(DIGITS)) u_comp (
        .en_i  (op_sub),
        .val_i (opnd_b),
        .val_o (b_eff)
    );

    assign raw_sum = {1'b0, opnd_a} + {1'b0, b_eff} + {{W{1'b0}}, carry_in};

    for (genvar g = 0; g < DIGITS; g++) begin : g_carry
        if (g < DIGITS - 1) begin : g_mid
            assign bin_cy[g] = raw_sum[DW*(g+1)] ^ opnd_a[DW*(g+1)] ^ b_eff[DW*(g+1)];
        end else begin : g_top
            assign bin_cy[g] = raw_sum[W];
        end
    end

    assign adj_cy[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_fix
        bcd_digit_fix u_fix (
            .raw_i       (raw_sum[g*DW +: DW]),
            .bin_carry_i (bin_cy[g]),
            .adj_carry_i (adj_cy[g]),
            .dig_o       (fixed_sum[g*DW +: DW]),
            .adj_carry_o (adj_cy[g+1])
        );
    end

    assign carry_nxt = adj_cy[DIGITS] | bin_cy[DIGITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_bcd    <= '0;
            half_carry <= 1'b0;
            dec_carry  <= 1'b0;
        end else if (op_valid) begin
            sum_bcd    <= fixed_sum;
            half_carry <= bin_cy[0];
            dec_carry  <= carry_nxt;
        end
    end
endmodule

// File: rtl/bcd_addsub_unit_chk.sv
module bcd_addsub_unit_chk #(
    parameter int DIGITS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    op_valid,
    input logic                    op_sub,
    input logic                    carry_in,
    input logic [DIGITS*4-1:0]     opnd_a,
    input logic [DIGITS*4-1:0]     opnd_b,
    input logic [DIGITS*4-1:0]     sum_bcd,
    input logic                    half_carry,
    input logic                    dec_carry
);
    function automatic logic all_legal(input logic [DIGITS*4-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    logic [3:0] b_low_eff;
    logic [4:0] low_nib_sum;
    always_comb begin
        b_low_eff   = op_sub ? (4'd9 - opnd_b[3:0]) : opnd_b[3:0];
        low_nib_sum = {1'b0, opnd_a[3:0]} + {1'b0, b_low_eff} + {4'd0, carry_in};
    end

    a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(sum_bcd) && $stable(half_carry) && $stable(dec_carry)));

    a_r3_legal_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && all_legal(opnd_a) && all_legal(opnd_b)) |=> all_legal(sum_bcd));

    a_r3_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sub && !carry_in && opnd_b == '0 && all_legal(opnd_a))
        |=> (sum_bcd == $past(opnd_a) && !dec_carry));

    a_r4_half_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (half_carry == $past(low_nib_sum[4])));

    a_r8_self_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sub && carry_in && opnd_a == opnd_b && all_legal(opnd_a))
        |=> (sum_bcd == '0 && dec_carry));
endmodule

bind bcd_addsub_unit bcd_addsub_unit_chk #(.DIGITS(DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sub     (op_sub),
    .carry_in   (carry_in),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sum_bcd    (sum_bcd),
    .half_carry (half_carry),
    .dec_carry  (dec_carry)
);

// File: tb/sim_bcd_addsub_unit.sv
`timescale 1ns/1ps
module sim_bcd_addsub_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] sum_bcd;
    logic       half_carry;
    logic       dec_carry;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_addsub_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sum_bcd(sum_bcd), .half_carry(half_carry), .dec_carry(dec_carry)
    );

    function automatic int dec_of(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] bcd_of(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic cmp(input string req, input logic [7:0] er, input logic ec, input logic eh);
        checks++;
        if (sum_bcd !== er || dec_carry !== ec || half_carry !== eh) begin
            failures++;
            $display("FAIL %s: actual res=%h cy=%b hc=%b expected res=%h cy=%b hc=%b",
                     req, sum_bcd, dec_carry, half_carry, er, ec, eh);
        end
    endtask

    task automatic do_op(input logic [7:0] a, input logic [7:0] b, input logic s, input logic c);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = s; carry_in = c; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic model_check(input string req, input logic [7:0] a, input logic [7:0] b,
                               input logic s, input logic c);
        int total;
        int bl;
        logic [7:0] er;
        logic ec, eh;
        total = dec_of(a) + (s ? (99 - dec_of(b)) : dec_of(b)) + int'(c);
        er = bcd_of(total % 100);
        ec = (total >= 100);
        bl = s ? (9 - int'(b[3:0])) : int'(b[3:0]);
        eh = ((int'(a[3:0]) + bl + int'(c)) > 15);
        do_op(a, b, s, c);
        cmp(req, er, ec, eh);
    endtask

    task automatic fixed_check(input string req, input logic [7:0] a, input logic [7:0] b,
                               input logic s, input logic c, input logic [7:0] er,
                               input logic ec, input logic eh);
        do_op(a, b, s, c);
        cmp(req, er, ec, eh);
    endtask

    task automatic t_reset();
        #5;
        cmp("R1 during reset", 8'h00, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after release", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        do_op(8'h39, 8'h28, 1'b0, 1'b0);
        @(negedge clk);
        opnd_a = 8'h99; opnd_b = 8'h99; op_sub = 1'b1; carry_in = 1'b1;
        @(negedge clk);
        opnd_a = 8'h12; opnd_b = 8'h77; op_sub = 1'b0;
        @(negedge clk);
        cmp("R2 hold while strobe low", 8'h67, 1'b0, 1'b1);
    endtask

    task automatic t_examples();
        fixed_check("R5 half-carry correction", 8'h39, 8'h28, 1'b0, 1'b0, 8'h67, 1'b0, 1'b1);
        fixed_check("R6 digit>9 correction",   8'h56, 8'h29, 1'b0, 1'b0, 8'h85, 1'b0, 1'b0);
        fixed_check("R10 max operands",         8'h99, 8'h99, 1'b0, 1'b1, 8'h99, 1'b1, 1'b1);
        fixed_check("R10 ripple correction",    8'h99, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        fixed_check("R3 plain add",             8'h12, 8'h34, 1'b0, 1'b0, 8'h46, 1'b0, 1'b0);
    endtask

    task automatic t_subtract();
        fixed_check("R8 tens complement sub",   8'h42, 8'h24, 1'b1, 1'b1, 8'h18, 1'b1, 1'b0);
        fixed_check("R8 self subtract",         8'h24, 8'h24, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
        fixed_check("R7 borrow out",            8'h24, 8'h42, 1'b1, 1'b1, 8'h82, 1'b0, 1'b0);
        fixed_check("R7 zero minus one",        8'h00, 8'h01, 1'b1, 1'b1, 8'h99, 1'b0, 1'b0);
    endtask

    task automatic t_chain();
        fixed_check("R9 carry-in to low digit", 8'h99, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
        fixed_check("R9 borrow-in on sub",      8'h50, 8'h20, 1'b1, 1'b0, 8'h29, 1'b1, 1'b0);
        fixed_check("R9 carry-in plain",        8'h08, 8'h01, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0);
    endtask

    task automatic t_sweep();
        for (int ia = 0; ia < 100; ia++) begin
            for (int ib = 0; ib < 100; ib++) begin
                model_check("R3 add sweep", bcd_of(ia), bcd_of(ib), 1'b0, 1'((ia + ib) % 2));
                model_check("R7 sub sweep", bcd_of(ia), bcd_of(ib), 1'b1, 1'((ia + 3 * ib) % 2));
            end
        end
        model_check("R4 half-carry on sub", 8'h07, 8'h01, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_examples();
        t_subtract();
        t_chain();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule